// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block listens to the clock and data lines of a two-wire I2C bus without ever driving them. It resynchronises both lines to the local clock. It recognises the two framing conditions a master uses to claim and release the bus: a START, where data falls while the clock is high, and a STOP, where data rises while the clock is high. For each condition it keeps a sticky status bit.

A local master that wants to take part in a multi-master bus uses these bits to decide when it may begin. The bus counts as free once a STOP has been seen. It also counts as free when no condition has been recorded since reset or since the block was enabled. A one-cycle interrupt pulse marks every detected condition. A master that enables the interrupt while the bus is busy is told the moment the bus is released.

Top module: `i2c_bus_watch`

## Requirements
- R1: While `rst_n` is low, `startSeen`, `stopSeen` and `irqPulse` are 0 and `busFree` is 1.
- R2: A START (synchronised SDA falls while synchronised SCL is high in both the previous and the current sample) sets `startSeen` to 1 and clears `stopSeen`. A repeated START leaves `startSeen` at 1.
- R3: A STOP (synchronised SDA rises while synchronised SCL is high in both samples) sets `stopSeen` to 1 and clears `startSeen`. The two bits are never 1 together.
- R4: `busFree` is 1 exactly when `stopSeen` is 1 or both status bits are 0.
- R5: With `irqEnable` high, a START gives `irqPulse` high for exactly one cycle. With the default two synchroniser stages, the status bit and the pulse appear on the third rising clock edge after the SDA change.
- R6: With `irqEnable` high, a STOP gives a one-cycle `irqPulse`, with the same latency as a START.
- R7: SDA changes while SCL is low, and SCL edges while SDA is steady, change neither status bit and give no pulse.
- R8: With `irqEnable` low, a condition still updates the status bits but gives no pulse. If `irqEnable` is raised while the bus is busy, the next STOP gives a pulse.
- R9: While `enable` is low, both status bits and `irqPulse` are held at 0. Conditions seen during that time are ignored and are not remembered once `enable` returns high.
- R10: An SDA change in the same sample in which SCL rises is not a condition, because SCL must already have been high in the previous sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset; ends any tracked transfer |
| enable | input | 1 | Module enable; low clears and freezes the status |
| irqEnable | input | 1 | Lets detected conditions raise `irqPulse` |
| sclIn | input | 1 | Bus clock line as seen at the pad (asynchronous) |
| sdaIn | input | 1 | Bus data line as seen at the pad (asynchronous) |
| startSeen | output | 1 | Sticky START status |
| stopSeen | output | 1 | Sticky STOP status |
| busFree | output | 1 | Bus may be claimed by a local master |
| irqPulse | output | 1 | One-cycle pulse per detected condition |

## Verification
Some properties are checked on every cycle: the two status bits never overlap, a set START bit always means the bus is busy, disabling clears the status on the next edge, a low interrupt enable suppresses the pulse, and every pulse comes with a status bit set. Other behaviour only the bench scenarios can show. These are the exact three-edge latency, the pulse width of one cycle, the rejection of SDA moves while SCL is low or rising, repeated START, and the late enabling of the interrupt on a busy bus. They also include what is forgotten across a disable and across a reset in mid-transfer.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  // One-cycle strobes sent from the line datapath to the status control
  typedef struct packed {
    logic startDet;
    logic stopDet;
  } busEvent_t;
endpackage

// File: rtl/i2cmon_datapath.sv
module i2cmon_datapath
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclIn,
  input  logic      sdaIn,
  output busEvent_t events
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic          sclPrev;
  logic          sdaPrev;

  // Synchroniser chain; idle bus level (high) after reset
  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[LAST-1:0], sclIn};
          sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
        end
      end
    end
  endgenerate

  logic sclNow;
  logic sdaNow;
  assign sclNow = sclPipe[LAST];
  assign sdaNow = sdaPipe[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  // Clock must be high in both samples around the data edge
  logic sclHeld;
  assign sclHeld = sclNow & sclPrev;

  always_comb begin
    events.startDet = sclHeld & sdaPrev & ~sdaNow;
    events.stopDet  = sclHeld & ~sdaPrev & sdaNow;
  end
endmodule

// File: rtl/i2cmon_control.sv
module i2cmon_control
  import i2cmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      irqEnable,
  input  busEvent_t events,
  output logic      startSeen,
  output logic      stopSeen,
  output logic      busFree,
  output logic      irqPulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
      irqPulse  <= 1'b0;
    end else if (!enable) begin
      startSeen <= 1'b0;
      stopSeen  <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (events.startDet) begin
        startSeen <= 1'b1;
        stopSeen  <= 1'b0;
      end else if (events.stopDet) begin
        stopSeen  <= 1'b1;
        startSeen <= 1'b0;
      end
      irqPulse <= irqEnable & (events.startDet | events.stopDet);
    end
  end

  assign busFree = stopSeen | (~startSeen & ~stopSeen);
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic irqEnable,
  input  logic sclIn,
  input  logic sdaIn,
  output logic startSeen,
  output logic stopSeen,
  output logic busFree,
  output logic irqPulse
);
  busEvent_t events;

  i2cmon_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .events (events)
  );

  i2cmon_control u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .irqEnable (irqEnable),
    .events    (events),
    .startSeen (startSeen),
    .stopSeen  (stopSeen),
    .busFree   (busFree),
    .irqPulse  (irqPulse)
  );
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic irqEnable,
  input logic startSeen,
  input logic stopSeen,
  input logic busFree,
  input logic irqPulse
);
  // R3
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(startSeen && stopSeen));

  // R4
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startSeen |-> !busFree);

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!startSeen && !stopSeen && !irqPulse));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irqEnable |=> !irqPulse);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> (startSeen || stopSeen));
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .irqEnable (irqEnable),
  .startSeen (startSeen),
  .stopSeen  (stopSeen),
  .busFree   (busFree),
  .irqPulse  (irqPulse)
);

// File: tb/sim_i2c_bus_watch.sv
`timescale 1ns/1ps
module sim_i2c_bus_watch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic irqEnable = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic startSeen, stopSeen, busFree, irqPulse;

  always #10 clk = ~clk;

  i2c_bus_watch u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irqEnable(irqEnable),
    .sclIn(sclIn), .sdaIn(sdaIn), .startSeen(startSeen), .stopSeen(stopSeen),
    .busFree(busFree), .irqPulse(irqPulse)
  );

  typedef struct {
    logic  s;
    logic  p;
    logic  free;
    logic  irq;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Monitor: pops an expected item each time the driver marks a sample point
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        compared++;
        if ({startSeen, stopSeen, busFree, irqPulse} !== {e.s, e.p, e.free, e.irq}) begin
          mismatched++;
          $display("FAIL %s: got S=%b P=%b free=%b irq=%b, expected S=%b P=%b free=%b irq=%b",
                   e.req, startSeen, stopSeen, busFree, irqPulse, e.s, e.p, e.free, e.irq);
        end
      end
    end
  end

  task automatic expectNow(input logic s, input logic p, input logic irq, input string req);
    expItem_t e;
    e.s = s; e.p = p; e.irq = irq; e.req = req;
    e.free = p | (~s & ~p);
    expQ.push_back(e);
    ->sampleEv;
    #1;
  endtask

  // Drive lines at a falling edge, then sample after three rising edges
  task automatic lines(input logic scl, input logic sda,
                       input logic s, input logic p, input logic irq, input string req);
    @(negedge clk);
    sclIn = scl;
    sdaIn = sda;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectNow(s, p, irq, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectNow(0, 0, 0, "R1 reset state");
    rst_n = 1'b1;
    enable = 1'b1;
    irqEnable = 1'b1;
    repeat (4) @(negedge clk);
    expectNow(0, 0, 0, "R4 free with no condition seen");

    // START, then the pulse must be gone one cycle later
    lines(1, 0, 1, 0, 1, "R2 R5 start detected");
    @(negedge clk);
    expectNow(1, 0, 0, "R5 pulse lasts one cycle");

    // Data bits: moves while SCL is low, SCL edges with SDA steady
    lines(0, 0, 1, 0, 0, "R7 scl falls");
    lines(0, 1, 1, 0, 0, "R7 sda rises while scl low");
    lines(1, 1, 1, 0, 0, "R7 scl rises sda steady");
    lines(1, 0, 1, 0, 1, "R2 repeated start");
    lines(0, 0, 1, 0, 0, "R7 scl low");

    // STOP
    lines(1, 0, 1, 0, 0, "R7 scl high sda low");
    lines(1, 1, 0, 1, 1, "R3 R6 stop detected");
    @(negedge clk);
    expectNow(0, 1, 0, "R6 pulse lasts one cycle");

    // SDA change coincident with SCL rise
    lines(0, 1, 0, 1, 0, "R7 scl low");
    lines(1, 0, 0, 1, 0, "R10 sda falls as scl rises");
    lines(0, 0, 0, 1, 0, "R7 scl low again");
    lines(0, 1, 0, 1, 0, "R7 sda rises with scl low");
    lines(1, 1, 0, 1, 0, "R7 back to idle");

    // Interrupt disabled, then enabled while busy
    irqEnable = 1'b0;
    lines(1, 0, 1, 0, 0, "R8 start with irq off");
    lines(0, 0, 1, 0, 0, "R7 scl low");
    lines(1, 0, 1, 0, 0, "R7 scl high");
    irqEnable = 1'b1;
    lines(1, 1, 0, 1, 1, "R8 stop pulses after late enable");

    // Module disable clears and ignores
    lines(1, 0, 1, 0, 1, "R2 start before disable");
    @(negedge clk);
    enable = 1'b0;
    lines(1, 0, 0, 0, 0, "R9 disable clears status");
    lines(1, 1, 0, 0, 0, "R9 stop ignored while off");
    lines(1, 0, 0, 0, 0, "R9 start ignored while off");
    lines(1, 1, 0, 0, 0, "R9 lines idle while off");
    @(negedge clk);
    enable = 1'b1;
    lines(1, 1, 0, 0, 0, "R9 nothing remembered after enable");

    // Reset during a transfer
    lines(1, 0, 1, 0, 1, "R2 start before reset");
    @(negedge clk);
    rst_n = 1'b0;
    sdaIn = 1'b1;
    @(negedge clk);
    expectNow(0, 0, 0, "R1 reset mid transfer");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expectNow(0, 0, 0, "R1 state after reset release");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule